// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one data byte into an asynchronous serial frame on a single output line. The line stays high when nothing is being sent. The shape of each frame comes from a format word that is read at run time. That word sets how many data bits are sent, whether a parity bit follows and which kind, and whether the stop period is one bit or one and a half bits. One bit of the word drives the line low for as long as it is set.

A byte arrives through a valid/ready handshake. Bit timing comes from outside the block on two strobes. `bit_en` marks the end of each whole bit period. `tick16` runs at sixteen times the bit rate and is used only to time the extra half stop bit. Baud generation, reception and buffering belong to neighbouring blocks.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset, `txd` is 1 and `tx_ready` is 1.
- R2: `tx_ready` is 1 only while no frame is in progress. A byte is accepted at a clock edge where `tx_valid` and `tx_ready` are both 1, and `tx_ready` is 0 from the next cycle. A `tx_valid` pulse while `tx_ready` is 0 is ignored and starts no frame.
- R3: A frame is a start bit of 0, followed by the data bits least significant first. `fmt[1:0]` sets the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected length have no effect on the line.
- R4: When `fmt[3]` is 1 and `fmt[5]` is 0, a parity bit follows the data. With `fmt[4]`=0 it makes the count of ones in data plus parity even. With `fmt[4]`=1 it makes that count odd. When `fmt[3]` is 0, no parity bit is sent.
- R5: When `fmt[3]` and `fmt[5]` are both 1, the parity bit is fixed: it is 1 when `fmt[4]`=0 and 0 when `fmt[4]`=1.
- R6: The stop period drives `txd` at 1. With `fmt[2]`=0, `tx_ready` returns on the `bit_en` edge that ends the first stop bit. With `fmt[2]`=1, the line stays high for 8 further `tick16` pulses, and `tx_ready` returns on the edge of the 8th.
- R7: `fmt[6]` is a live break control. One cycle after it is seen high, `txd` is 0 in any state. A frame in progress keeps advancing underneath, and the line shows that frame's bit again one cycle after `fmt[6]` falls.
- R8: `fmt[5:0]` and `tx_data` are captured when the byte is accepted. Changing them during a frame has no effect on that frame.
- R9: Each frame bit holds until a `bit_en` pulse is sampled, and `txd` moves to the next bit at that edge. `tick16` has no effect outside the half stop period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Strobe at sixteen times the bit rate |
| bit_en | input | 1 | Strobe at the end of each bit period |
| fmt | input | 7 | Format word: [1:0] length, [2] long stop, [3] parity on, [4] odd, [5] fixed parity, [6] break |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Idle and able to accept |
| txd | output | 1 | Serial line, high when idle |

## Verification
The break override and the frame sequencer can both act in the same cycle. In that case break sets the line while the sequencer keeps stepping through the bits. The bench raises the break control part way through a frame, keeps it across several data bits, and drops it again before the frame ends. It checks that the line reads 0 for those bits, that the following bits match the expected frame exactly, and that the handshake comes back on the normal edge. The full format sweep also rewrites the format word right after each acceptance, which shows that sampling and live break control stay separate.

// File: rtl/uft_pkg.sv
package uft_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HALF
  } uft_state_e;

  typedef struct packed {
    logic       par_stick;
    logic       par_odd;
    logic       par_en;
    logic       stop_long;
    logic [1:0] wlen;
  } uft_fmt_t;

  function automatic uft_fmt_t uft_decode(input logic [5:0] w);
    uft_fmt_t f;
    f.wlen      = w[1:0];
    f.stop_long = w[2];
    f.par_en    = w[3];
    f.par_odd   = w[4];
    f.par_stick = w[5];
    return f;
  endfunction

endpackage

// File: rtl/uft_fmt_hold.sv
module uft_fmt_hold
  import uft_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int CW       = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [5:0]          fmt_in,
  input  logic [MAX_BITS-1:0] data_in,
  output logic [MAX_BITS-1:0] data_q,
  output logic [CW-1:0]       nbits_q,
  output logic                par_en_q,
  output logic                stop_long_q,
  output logic                par_bit_q
);
  localparam int MIN_BITS = MAX_BITS - 3;

  uft_fmt_t            f_in;
  logic [CW-1:0]       len_in;
  logic [MAX_BITS-1:0] mask_in;
  logic [MAX_BITS-1:0] data_m;
  logic                par_calc;

  assign f_in   = uft_decode(fmt_in);
  assign len_in = CW'(MIN_BITS) + CW'(f_in.wlen);

  for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
    assign mask_in[i] = (CW'(i) < len_in);
  end

  assign data_m = data_in & mask_in;

  always_comb begin
    if (f_in.par_stick) par_calc = ~f_in.par_odd;
    else                par_calc = (^data_m) ^ f_in.par_odd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q      <= '0;
      nbits_q     <= CW'(MIN_BITS);
      par_en_q    <= 1'b0;
      stop_long_q <= 1'b0;
      par_bit_q   <= 1'b0;
    end else if (load) begin
      data_q      <= data_m;
      nbits_q     <= len_in;
      par_en_q    <= f_in.par_en;
      stop_long_q <= f_in.stop_long;
      par_bit_q   <= par_calc;
    end
  end
endmodule

// File: rtl/uft_half_timer.sv
module uft_half_timer #(
  parameter int HALF_TICKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic done
);
  localparam int HW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;

  logic [HW-1:0] cnt_q;
  logic          act_q;

  assign done = act_q && tick && (cnt_q == HW'(HALF_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (done) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (act_q && tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/uft_seq.sv
module uft_seq
  import uft_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int CW       = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_en,
  input  logic                half_done,
  input  logic                tx_valid,
  input  logic                brk,
  input  logic [MAX_BITS-1:0] data_q,
  input  logic [CW-1:0]       nbits,
  input  logic                par_en,
  input  logic                stop_long,
  input  logic                par_bit,
  output logic                tx_ready,
  output logic                accept,
  output logic                half_start,
  output logic                txd
);
  uft_state_e          st_q, st_n;
  logic [MAX_BITS-1:0] sh_q, sh_n;
  logic [CW-1:0]       cnt_q, cnt_n;
  logic                line_n;
  logic                txd_q;

  assign tx_ready = (st_q == ST_IDLE);
  assign accept   = tx_valid && tx_ready;
  assign txd      = txd_q;

  always_comb begin
    st_n       = st_q;
    sh_n       = sh_q;
    cnt_n      = cnt_q;
    half_start = 1'b0;
    case (st_q)
      ST_IDLE:  if (tx_valid) st_n = ST_START;
      ST_START: if (bit_en) begin
        st_n  = ST_DATA;
        sh_n  = data_q;
        cnt_n = '0;
      end
      ST_DATA:  if (bit_en) begin
        sh_n = sh_q >> 1;
        if (cnt_q == nbits - 1'b1) st_n = par_en ? ST_PAR : ST_STOP;
        else                       cnt_n = cnt_q + 1'b1;
      end
      ST_PAR:   if (bit_en) st_n = ST_STOP;
      ST_STOP:  if (bit_en) begin
        if (stop_long) begin
          st_n       = ST_HALF;
          half_start = 1'b1;
        end else begin
          st_n = ST_IDLE;
        end
      end
      ST_HALF:  if (half_done) st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    case (st_n)
      ST_START: line_n = 1'b0;
      ST_DATA:  line_n = sh_n[0];
      ST_PAR:   line_n = par_bit;
      default:  line_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      sh_q  <= '0;
      cnt_q <= '0;
      txd_q <= 1'b1;
    end else begin
      st_q  <= st_n;
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
      txd_q <= brk ? 1'b0 : line_n;
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int MAX_BITS   = 8,
  parameter int HALF_TICKS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick16,
  input  logic                bit_en,
  input  logic [6:0]          fmt,
  input  logic [MAX_BITS-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic                txd
);
  localparam int CW = $clog2(MAX_BITS + 1);

  logic                accept;
  logic                half_start;
  logic                half_done;
  logic [MAX_BITS-1:0] data_q;
  logic [CW-1:0]       nbits_q;
  logic                par_en_q;
  logic                stop_long_q;
  logic                par_bit_q;

  uft_fmt_hold #(.MAX_BITS(MAX_BITS), .CW(CW)) u_hold (
    .clk         (clk),
    .rst         (rst),
    .load        (accept),
    .fmt_in      (fmt[5:0]),
    .data_in     (tx_data),
    .data_q      (data_q),
    .nbits_q     (nbits_q),
    .par_en_q    (par_en_q),
    .stop_long_q (stop_long_q),
    .par_bit_q   (par_bit_q)
  );

  uft_half_timer #(.HALF_TICKS(HALF_TICKS)) u_half (
    .clk   (clk),
    .rst   (rst),
    .start (half_start),
    .tick  (tick16),
    .done  (half_done)
  );

  uft_seq #(.MAX_BITS(MAX_BITS), .CW(CW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .half_done  (half_done),
    .tx_valid   (tx_valid),
    .brk        (fmt[6]),
    .data_q     (data_q),
    .nbits      (nbits_q),
    .par_en     (par_en_q),
    .stop_long  (stop_long_q),
    .par_bit    (par_bit_q),
    .tx_ready   (tx_ready),
    .accept     (accept),
    .half_start (half_start),
    .txd        (txd)
  );
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic brk,
  input logic bit_en,
  input logic tick16,
  input logic tx_valid,
  input logic tx_ready,
  input logic txd
);
  logic seen_q;
  logic brk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      brk_q  <= brk;
    end
  end

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (rst)
    (seen_q && tx_ready && !brk_q) |-> txd);

  assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_ready_falls_on_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $fell(tx_ready)) |-> $past(tx_valid));

  assert_start_bit_low_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && !brk) |=> !txd);

  assert_break_forces_low_R7: assert property (@(posedge clk) disable iff (rst)
    (seen_q && brk_q) |-> !txd);

  assert_line_holds_without_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !tx_ready && !bit_en && !tick16 && !brk && !brk_q) |=> $stable(txd));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .brk      (fmt[6]),
  .bit_en   (bit_en),
  .tick16   (tick16),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .txd      (txd)
);

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       bit_en = 1'b0;
  logic [6:0] fmt = '0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       txd;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  uart_frame_tx u_dut (
    .clk(clk), .rst(rst), .tick16(tick16), .bit_en(bit_en), .fmt(fmt),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic t, input logic b);
    tick16 = t;
    bit_en = b;
    @(posedge clk);
    @(negedge clk);
    tick16 = 1'b0;
    bit_en = 1'b0;
  endtask

  // brk_lo > brk_hi means no break window
  task automatic send(input logic [7:0] d, input logic [5:0] f, input int brk_lo, input int brk_hi);
    logic exp_bits[12];
    int   n;
    int   len;
    int   ones;
    len = 5 + int'(f[1:0]);
    n = 0;
    exp_bits[n++] = 1'b0;
    ones = 0;
    for (int i = 0; i < len; i++) begin
      exp_bits[n++] = d[i];
      ones += int'(d[i]);
    end
    if (f[3]) begin
      if (f[5]) exp_bits[n++] = ~f[4];
      else      exp_bits[n++] = ((ones % 2) == 1) ^ f[4];
    end
    exp_bits[n++] = 1'b1;
    fmt[5:0] = f;
    tx_data  = d;
    tx_valid = 1'b1;
    cyc(1'b0, 1'b0);
    tx_valid = 1'b0;
    chk(tx_ready, 1'b0, "R2 ready low after accept");
    fmt[5:0] = ~f;
    tx_data  = ~d;
    for (int k = 0; k < n; k++) begin
      fmt[6] = (k >= brk_lo) && (k <= brk_hi);
      for (int j = 0; j < 32; j++) begin
        if (k == 2 && j == 5) tx_valid = 1'b1;
        cyc(j % 2 == 1, j == 31);
        tx_valid = 1'b0;
        if (j == 15) begin
          if (fmt[6]) chk(txd, 1'b0, "R7 break holds line low");
          else if (k == 0) chk(txd, exp_bits[k], "R3 start bit");
          else if (k <= len) chk(txd, exp_bits[k], "R3 R8 data bit");
          else if (k == n - 1) chk(txd, exp_bits[k], "R6 stop bit");
          else chk(txd, exp_bits[k], f[5] ? "R5 fixed parity bit" : "R4 parity bit");
          if (k < n - 1) chk(tx_ready, 1'b0, "R2 R9 busy mid frame");
        end
      end
    end
    fmt[6] = 1'b0;
    if (!f[2]) begin
      chk(tx_ready, 1'b1, "R6 ready after single stop");
    end else begin
      for (int j = 0; j < 16; j++) begin
        cyc(j % 2 == 1, 1'b0);
        if (j == 13) begin
          chk(tx_ready, 1'b0, "R6 still in half stop after 7 ticks");
          chk(txd, 1'b1, "R6 half stop high");
        end
      end
      chk(tx_ready, 1'b1, "R6 ready after 8th tick");
    end
    repeat (3) cyc(1'b0, 1'b0);
    chk(tx_ready, 1'b1, "R2 busy-time valid started nothing");
    chk(txd, 1'b1, "R2 line idle after frame");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(txd, 1'b1, "R1 reset line");
    chk(tx_ready, 1'b1, "R1 reset ready");

    // R9: strobes while idle do nothing
    for (int j = 0; j < 6; j++) cyc(1'b1, j == 5);
    chk(txd, 1'b1, "R9 idle strobes ignored");
    chk(tx_ready, 1'b1, "R9 idle strobes ready");

    // R7: break while idle
    fmt[6] = 1'b1;
    cyc(1'b0, 1'b0);
    chk(txd, 1'b0, "R7 idle break");
    repeat (4) cyc(1'b1, 1'b0);
    chk(txd, 1'b0, "R7 idle break held");
    chk(tx_ready, 1'b1, "R7 break leaves ready");
    fmt[6] = 1'b0;
    cyc(1'b0, 1'b0);
    chk(txd, 1'b1, "R7 release break");

    // sweep every format, three data patterns each
    for (int fi = 0; fi < 64; fi++) begin
      for (int di = 0; di < 3; di++) begin
        send(8'((fi * 37 + di * 91) ^ 8'hA5), 6'(fi), 1, 0);
      end
    end

    // R7: break over data bits 2..4, frame continues beneath
    send(8'h5B, 6'b001111, 2, 4);
    send(8'hC3, 6'b011011, 6, 9);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule